// File: doc/BRIEF.md
# Debugger Console Output Packet Framer

This block turns a stream of console characters into debugger "output" packets and carries out the acknowledgement handshake for each packet. Characters enter on a valid/ready port and are stored in a line buffer. A newline, or a buffer that has just filled, starts a flush. The flush sends `$`, then `O`, then every stored character as two uppercase hex digits, then `#` and a two-digit checksum. Each byte goes out through a valid/ready byte port toward a UART transmitter.

After the last checksum digit, the block waits for one byte from the UART receiver. A `+` ends the transfer. A Ctrl-C byte also ends the transfer and raises a one-cycle break request. Any other byte makes the block send the whole packet again. While a flush is in progress, the character input is closed.

Top module: `dbg_out_framer`

## Requirements
- R1: An input character 0x0D is accepted but never stored, and it never appears in any payload.
- R2: An accepted 0x0A starts a packet with the characters stored so far. The 0x0A itself is not part of the payload.
- R3: Once DEPTH characters (default 100) are stored, a packet starts without any newline.
- R4: Every packet begins with the byte 0x24 (`$`) followed by the byte 0x4F (`O`).
- R5: Each stored character is sent as two uppercase ASCII hex digits (0-9 as 0x30-0x39, A-F as 0x41-0x46), high nibble first, in the order the characters arrived.
- R6: After the payload comes 0x23 (`#`), then the checksum as two uppercase hex digits, high nibble first. The checksum is the sum modulo 256 of every byte sent after `$` and before `#`.
- R7: When the block is waiting for a reply and receives 0x2B (`+`), the transfer ends. The input reopens and the stored count returns to zero.
- R8: When the block is waiting for a reply and receives any byte other than 0x2B or 0x03, it sends the identical packet again.
- R9: When the block is waiting for a reply and receives 0x03, it drives `brk_pulse` high for exactly one cycle. It sends nothing more, and the stored count returns to zero.
- R10: `in_ready` is low from the cycle after a flush starts until the transfer ends. Received bytes that arrive before the packet has been fully sent have no effect.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R12: A newline with an empty buffer sends exactly `$O#4F`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Console character is offered |
| in_data | input | 8 | Console character |
| in_ready | output | 1 | Block accepts a character |
| tx_valid | output | 1 | Packet byte is offered to the transmitter |
| tx_data | output | 8 | Packet byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| brk_pulse | output | 1 | One-cycle break request after a Ctrl-C reply |

## Verification
The assertions assume that the character source honours `in_ready`, that `rx_valid` is a one-cycle strobe per received byte, and that the transmitter eventually raises `tx_ready`. The bench drives characters only at falling edges in which it has just seen `in_ready` high. It pulses `rx_valid` for a single cycle. It produces `tx_ready` from a register that either stays high or follows a repeating stall pattern, so every offered byte is eventually taken.

// File: rtl/dof_pkg.sv
package dof_pkg;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_ACK = 8'h2B;
  localparam logic [7:0] CH_BRK = 8'h03;
  localparam logic [7:0] CH_SOP = 8'h24;
  localparam logic [7:0] CH_OUT = 8'h4F;
  localparam logic [7:0] CH_EOP = 8'h23;

  typedef enum logic [3:0] {
    ST_COLLECT, ST_DOLLAR, ST_OH, ST_FETCH, ST_HEX_HI, ST_HEX_LO,
    ST_HASH, ST_SUM_HI, ST_SUM_LO, ST_AWAIT
  } dof_state_e;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/dof_line_mem.sv
module dof_line_mem #(
  parameter int DEPTH = 100,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dof_seq.sv
module dof_seq
  import dof_pkg::*;
#(
  parameter int DEPTH = 100,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          brk_pulse
);
  dof_state_e state, nxt;
  logic [CW-1:0] cnt, idx;
  logic [7:0]    csum, cur_byte;
  logic          accept;

  assign accept  = in_valid && in_ready;
  assign wr_en   = accept && (in_data != CH_CR) && (in_data != CH_LF);
  assign wr_addr = cnt[AW-1:0];
  assign wr_data = in_data;
  assign rd_addr = idx[AW-1:0];

  always_comb begin
    cur_byte = 8'h00;
    nxt      = state;
    case (state)
      ST_DOLLAR: begin cur_byte = CH_SOP; nxt = ST_OH; end
      ST_OH:     begin cur_byte = CH_OUT; nxt = (cnt == '0) ? ST_HASH : ST_FETCH; end
      ST_HEX_HI: begin cur_byte = hex_ascii(rd_data[7:4]); nxt = ST_HEX_LO; end
      ST_HEX_LO: begin
        cur_byte = hex_ascii(rd_data[3:0]);
        nxt = (idx + CW'(1) == cnt) ? ST_HASH : ST_FETCH;
      end
      ST_HASH:   begin cur_byte = CH_EOP; nxt = ST_SUM_HI; end
      ST_SUM_HI: begin cur_byte = hex_ascii(csum[7:4]); nxt = ST_SUM_LO; end
      ST_SUM_LO: begin cur_byte = hex_ascii(csum[3:0]); nxt = ST_AWAIT; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      cnt       <= '0;
      idx       <= '0;
      csum      <= '0;
      in_ready  <= 1'b1;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= 1'b0;
      case (state)
        ST_COLLECT: begin
          if (accept && in_data != CH_CR) begin
            if (in_data == CH_LF || cnt + CW'(1) == CW'(DEPTH)) begin
              state    <= ST_DOLLAR;
              in_ready <= 1'b0;
              csum     <= '0;
              idx      <= '0;
            end
            if (in_data != CH_LF) cnt <= cnt + CW'(1);
          end
        end
        ST_FETCH: state <= ST_HEX_HI;
        ST_AWAIT: begin
          if (rx_valid) begin
            if (rx_data == CH_ACK || rx_data == CH_BRK) begin
              state     <= ST_COLLECT;
              cnt       <= '0;
              in_ready  <= 1'b1;
              brk_pulse <= (rx_data == CH_BRK);
            end else begin
              state <= ST_DOLLAR;
              csum  <= '0;
              idx   <= '0;
            end
          end
        end
        default: begin
          if (!tx_valid) begin
            tx_valid <= 1'b1;
            tx_data  <= cur_byte;
          end else if (tx_ready) begin
            tx_valid <= 1'b0;
            state    <= nxt;
            if (state == ST_OH || state == ST_HEX_HI || state == ST_HEX_LO)
              csum <= csum + tx_data;
            if (state == ST_HEX_LO) idx <= idx + CW'(1);
          end
        end
      endcase
    end
  end

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R9
  brk_single_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |=> !brk_pulse);
  // R9
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> $past(rx_valid && rx_data == CH_BRK));
  // R10
  lf_closes_input_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_data == CH_LF |=> !in_ready);
  // R10
  quiet_while_open_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !tx_valid);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R7
  ack_reopens_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_AWAIT && rx_valid && rx_data == CH_ACK |=> in_ready && cnt == '0);
endmodule

// File: rtl/dbg_out_framer.sv
module dbg_out_framer
  import dof_pkg::*;
#(
  parameter int DEPTH = 100,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       brk_pulse
);
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  dof_line_mem #(.DEPTH(DEPTH), .W(8)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  dof_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .brk_pulse(brk_pulse)
  );

  // R1
  cr_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_data == CH_CR |-> !wr_en);
endmodule

// File: tb/test_dbg_out_framer.sv
module test_dbg_out_framer;
  localparam int DEPTH = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic brk_pulse;

  int checks = 0;
  int failures = 0;
  logic stall = 1'b0;
  logic [1:0] rdy_ctr = 2'b00;

  logic [7:0] cap   [512];
  logic [7:0] exp_b [512];
  logic [7:0] pay   [128];
  int cap_n = 0;
  int exp_n = 0;

  always #10 clk = ~clk;

  dbg_out_framer #(.DEPTH(DEPTH)) i_dbg_out_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .brk_pulse(brk_pulse)
  );

  always @(posedge clk) begin
    rdy_ctr  <= rdy_ctr + 2'd1;
    tx_ready <= !stall || (rdy_ctr == 2'b11);
  end

  always @(negedge clk)
    if (tx_valid && tx_ready && cap_n < 512) begin
      cap[cap_n] = tx_data;
      cap_n = cap_n + 1;
    end

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic build_exp(input int n);
    logic [7:0] s;
    exp_b[0] = 8'h24;
    exp_b[1] = 8'h4F;
    exp_n = 2;
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n]   = hx(pay[i][7:4]);
      exp_b[exp_n+1] = hx(pay[i][3:0]);
      exp_n += 2;
    end
    s = 8'h00;
    for (int i = 1; i < exp_n; i++) s = s + exp_b[i];
    exp_b[exp_n]   = 8'h23;
    exp_b[exp_n+1] = hx(s[7:4]);
    exp_b[exp_n+2] = hx(s[3:0]);
    exp_n += 3;
  endtask

  task automatic clr_cap();
    @(posedge clk);
    cap_n = 0;
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    int t = 0;
    while (cap_n < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic reply(input logic [7:0] b);
    @(negedge clk);
    @(negedge clk);
    cap_n    = 0;
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic check_pkt(input string tag);
    int bad = -1;
    checks++;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
    if (cap_n != exp_n) begin
      failures++;
      $display("FAIL %s length actual=%0d expected=%0d", tag, cap_n, exp_n);
    end else if (bad >= 0) begin
      failures++;
      $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, bad, cap[bad], exp_b[bad]);
    end
  endtask

  task automatic t_reset();
    chk("R10 in_ready after reset", 32'(in_ready), 1);
    chk("R11 tx_valid after reset", 32'(tx_valid), 0);
    chk("R9 brk_pulse after reset", 32'(brk_pulse), 0);
  endtask

  task automatic t_basic();
    clr_cap();
    pay[0] = 8'h41; pay[1] = 8'h42; pay[2] = 8'hFE; pay[3] = 8'h5A;
    send_char(8'h41); send_char(8'h0D); send_char(8'h42);
    send_char(8'hFE); send_char(8'h0D); send_char(8'h5A);
    send_char(8'h0A);
    chk("R10 in_ready low after newline", 32'(in_ready), 0);
    build_exp(4);
    wait_bytes(exp_n);
    check_pkt("R1 R2 R5 packet with CR dropped");
    chk("R4 first byte", 32'(cap[0]), 32'h24);
    chk("R4 second byte", 32'(cap[1]), 32'h4F);
    chk("R5 FE high digit", 32'(cap[6]), 32'h46);
    chk("R6 hash position", 32'(cap[exp_n-3]), 32'h23);
    reply(8'h2B);
    chk("R7 in_ready after ack", 32'(in_ready), 1);
  endtask

  task automatic t_empty();
    clr_cap();
    send_char(8'h0A);
    wait_bytes(5);
    build_exp(0);
    check_pkt("R12 empty packet");
    chk("R12 checksum high", 32'(cap[3]), 32'h34);
    chk("R12 checksum low", 32'(cap[4]), 32'h46);
    reply(8'h2B);
  endtask

  task automatic t_nak();
    clr_cap();
    pay[0] = 8'h7A;
    send_char(8'h7A); send_char(8'h0A);
    build_exp(1);
    wait_bytes(exp_n);
    check_pkt("R8 first send");
    reply(8'h78);
    wait_bytes(exp_n);
    check_pkt("R8 resend after other byte");
    reply(8'h2B);
    chk("R7 in_ready after ack following resend", 32'(in_ready), 1);
  endtask

  task automatic t_brk();
    clr_cap();
    pay[0] = 8'h71; pay[1] = 8'h72;
    send_char(8'h71); send_char(8'h72); send_char(8'h0A);
    build_exp(2);
    wait_bytes(exp_n);
    check_pkt("R9 packet before break");
    reply(8'h03);
    chk("R9 brk_pulse high", 32'(brk_pulse), 1);
    @(negedge clk);
    chk("R9 brk_pulse one cycle", 32'(brk_pulse), 0);
    repeat (20) @(negedge clk);
    chk("R9 nothing sent after break", 32'(cap_n), 0);
    chk("R9 in_ready after break", 32'(in_ready), 1);
    send_char(8'h0A);
    wait_bytes(5);
    build_exp(0);
    check_pkt("R9 count cleared after break");
    reply(8'h2B);
  endtask

  task automatic t_ignore_rx();
    clr_cap();
    pay[0] = 8'h6B;
    send_char(8'h6B); send_char(8'h0A);
    build_exp(1);
    wait_bytes(3);
    rx_valid = 1'b1; rx_data = 8'h2B;
    @(negedge clk);
    rx_valid = 1'b0;
    wait_bytes(exp_n);
    check_pkt("R10 packet completes despite early reply");
    repeat (10) @(negedge clk);
    chk("R10 still waiting after early reply", 32'(in_ready), 0);
    reply(8'h2B);
    chk("R7 reopen after real ack", 32'(in_ready), 1);
  endtask

  task automatic t_full();
    clr_cap();
    for (int i = 0; i < DEPTH; i++) begin
      pay[i] = 8'h30 + 8'(i % 40);
      send_char(pay[i]);
    end
    chk("R3 in_ready low when full", 32'(in_ready), 0);
    build_exp(DEPTH);
    wait_bytes(exp_n);
    check_pkt("R3 R5 R6 full buffer packet");
    reply(8'h2B);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    clr_cap();
    pay[0] = 8'h00; pay[1] = 8'hC3; pay[2] = 8'h9F;
    send_char(8'h00); send_char(8'hC3); send_char(8'h9F); send_char(8'h0A);
    build_exp(3);
    wait_bytes(exp_n);
    check_pkt("R11 packet under transmitter stalls");
    reply(8'h2B);
    stall = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_nak();
    t_brk();
    t_ignore_rx();
    t_full();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule